// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block sits between a simple host and a 2M x 32 EDO DRAM array made of two ranks. Each rank has two 16-bit devices side by side. The host issues one 32-bit read or write at a time over a valid/ready request carrying a 21-bit word address, write data and four byte enables. Read data returns later with a one-cycle valid pulse.

On the memory side the controller drives four outputs:
- a multiplexed 10-bit row/column address;
- four active-low row strobes, used in pairs, one pair per rank;
- four active-low column strobes, one per byte lane;
- active-low write enable and output enable.

Write data leaves on a separate bus with a drive-enable. Read data comes back on an input bus. Every timing figure is a parameter in clock cycles (defaults assume a 100 MHz clock and the faster speed grade).

After reset the controller waits out a long power-up pause. It then runs a fixed number of CAS-before-RAS refresh cycles before it accepts any host traffic. From then on, a free-running interval counter marks a refresh as pending once per interval. A pending refresh is served ahead of a waiting host request, but only once the current access has finished.

The state machine has eight states:
- POWERUP: the pause.
- IDLE: waiting for work.
- ROW: row address out, rank strobes low.
- COL: column address out, lane strobes low.
- PRECH: row precharge after an access.
- CBR_CAS: all column strobes low.
- CBR_RAS: all row strobes low as well.
- CBR_PRECH: precharge after a refresh.

The transitions are:
- POWERUP to IDLE when the pause ends.
- IDLE to CBR_CAS while initialization refreshes remain, or when a refresh is pending.
- IDLE to ROW on an accepted request.
- ROW to COL after the row-to-column delay.
- COL to PRECH once the row strobe has been low for its minimum width.
- PRECH to IDLE.
- CBR_CAS to CBR_RAS after the CAS setup time.
- CBR_RAS to CBR_PRECH after the minimum row strobe width.
- CBR_PRECH to IDLE.

Top module: `edo_ctrl`

## Requirements
- R1: After reset all row and column strobes, write enable and output enable are high and req_ready is low. No row strobe falls before INIT_CYCLES clock cycles have passed.
- R2: After the pause, exactly INIT_REFS (default 8) refresh cycles complete before req_ready first rises.
- R3: A refresh cycle drives all four column strobes low at least T_CSR cycles before all four row strobes fall. Write enable and output enable stay high while the row strobes are low, and the row strobes stay low for T_RAS cycles.
- R4: After initialization, refreshes start once per REF_INTERVAL cycles. Successive refresh starts are REF_INTERVAL cycles apart, within 16 cycles either way, even under back-to-back host traffic.
- R5: A refresh never starts while an access holds its row strobes low: all row strobes are high in the cycle before a refresh's row strobes fall. A pending refresh is served before a host request that is already waiting.
- R6: Host address bit 20 selects the rank, bits 19:10 the row and bits 9:0 the column. For rank 0, row strobes 0 and 2 fall (ras_n = 4'b1010); for rank 1, strobes 1 and 3 fall (4'b0101). The row is on mem_addr when the strobes fall and the column when the column strobes fall. Data in one rank is independent of the other.
- R7: Column strobe i (bits 8i+7:8i) falls in an access exactly when byte enable i is set. A write changes only the enabled bytes.
- R8: In a write, write enable is low from the row phase, so it is already low before any column strobe falls. The data bus is driven with the write data and output enable stays high for the whole access.
- R9: In a read, write enable stays high, the data bus is not driven and output enable is low while the column strobes are low. Data is captured at the end of the column phase and rd_valid pulses for one cycle. Lanes with byte enable 0 read as zero.
- R10: Each rank's row strobe stays low at least T_RAS cycles and high at least T_RP cycles. Successive falls of the same strobe are at least T_RC cycles apart. The column strobes fall exactly T_RCD cycles after the row strobes in an access.
- R11: req_ready is high only when the controller is idle, initialized and has no refresh pending, and all strobes are then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address: rank, row, column |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i for bits 8i+7:8i |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data, disabled lanes zero |
| mem_addr | output | 10 | Multiplexed row/column address |
| mem_ras_n | output | 4 | Row strobes, active low, paired per rank |
| mem_cas_n | output | 4 | Byte-lane column strobes, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 32 | Write data to the array |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 32 | Read data from the array |

## Verification
A bench model of the array stores bytes on each column strobe fall and returns them on reads. It fills unselected lanes with a marker, so a wrong lane mask or a wrong rank shows up as corrupted data. Full-word writes to corner addresses (all zeros, all ones, rank boundaries) separate the row, column and rank mapping. Paired addresses that differ only in the rank bit catch a wrong strobe pair. Overlapping partial-byte writes followed by masked reads catch lane-to-strobe swaps and missing read masking. A long back-to-back stream shows that refresh is neither starved by host traffic nor allowed to cut into an access. A quiet stretch afterwards measures the refresh spacing alone.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PRECH,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_CBR_PRECH
    } edo_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
    parameter int INTERVAL = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] tick;
    logic          wrap;

    assign wrap = run && (tick == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick    <= '0;
            pending <= 1'b0;
        end else begin
            if (!run || wrap) tick <= '0;
            else              tick <= tick + 1'b1;
            // a new interval expiry outranks a same-cycle acknowledge
            if (wrap)     pending <= 1'b1;
            else if (ack) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/edo_strobe_map.sv
module edo_strobe_map #(
    parameter int RANK_BITS = 1,
    parameter int DEVS      = 2,
    parameter int LANES     = 4
) (
    input  logic [RANK_BITS-1:0]          rank,
    input  logic [LANES-1:0]              lanes,
    input  logic                          row_act,
    input  logic                          col_act,
    input  logic                          ref_cas,
    input  logic                          ref_ras,
    output logic [(DEVS<<RANK_BITS)-1:0]  ras_n,
    output logic [LANES-1:0]              cas_n
);
    localparam int RANKS = 1 << RANK_BITS;
    localparam int LINES = DEVS << RANK_BITS;

    // row strobe i serves rank (i mod RANKS); all devices of a rank move together
    for (genvar i = 0; i < LINES; i++) begin : g_ras
        assign ras_n[i] = ~(ref_ras | (row_act & (rank == RANK_BITS'(i % RANKS))));
    end

    for (genvar j = 0; j < LANES; j++) begin : g_cas
        assign cas_n[j] = ~(ref_cas | (col_act & lanes[j]));
    end
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
    import edo_pkg::*;
#(
    parameter int RANK_BITS    = 1,
    parameter int DEVS         = 2,
    parameter int ROW_W        = 10,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 32,
    parameter int T_RCD        = 2,
    parameter int T_RAS        = 5,
    parameter int T_RP         = 3,
    parameter int T_RC         = 9,
    parameter int T_CSR        = 1,
    parameter int REF_INTERVAL = 3125,
    parameter int INIT_CYCLES  = 20000,
    parameter int INIT_REFS    = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic                                   req_write,
    input  logic [RANK_BITS+ROW_W+COL_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]                      req_wdata,
    input  logic [DATA_W/8-1:0]                    req_be,
    output logic                                   rd_valid,
    output logic [DATA_W-1:0]                      rd_data,
    output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] mem_addr,
    output logic [(DEVS<<RANK_BITS)-1:0]           mem_ras_n,
    output logic [DATA_W/8-1:0]                    mem_cas_n,
    output logic                                   mem_we_n,
    output logic                                   mem_oe_n,
    output logic [DATA_W-1:0]                      mem_dq_out,
    output logic                                   mem_dq_oe,
    input  logic [DATA_W-1:0]                      mem_dq_in
);
    localparam int LANES   = DATA_W / BYTE_W;
    localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int T_COL   = T_RAS - T_RCD;
    localparam int T_PRE   = (T_RP > T_RC - T_RAS) ? T_RP : (T_RC - T_RAS);
    localparam int BIG_T   = (T_RC > T_PRE) ? T_RC : T_PRE;
    localparam int CNT_MAX = (INIT_CYCLES > BIG_T) ? INIT_CYCLES : BIG_T;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int IW      = $clog2(INIT_REFS + 1);

    edo_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_load;
    logic          cnt_zero;
    logic [IW-1:0] init_cnt;
    logic          init_done;
    logic          ref_pending, ref_ack, accept;

    logic [RANK_BITS-1:0] lat_rank;
    logic [ROW_W-1:0]     lat_row;
    logic [COL_W-1:0]     lat_col;
    logic                 lat_write;
    logic [DATA_W-1:0]    lat_wdata;
    logic [LANES-1:0]     lat_be;
    logic [DATA_W-1:0]    lane_mask;

    logic row_act, col_act, ref_cas, ref_ras;

    assign cnt_zero  = (cnt == '0);
    assign req_ready = (state == ST_IDLE) && init_done && !ref_pending;
    assign ref_ack   = (state == ST_IDLE) && init_done && ref_pending;
    assign accept    = req_valid && req_ready;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_POWERUP;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POWERUP:   if (cnt_zero) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (!init_done || ref_pending) state_nx = ST_CBR_CAS;
                else if (req_valid)            state_nx = ST_ROW;
            end
            ST_ROW:       if (cnt_zero) state_nx = ST_COL;
            ST_COL:       if (cnt_zero) state_nx = ST_PRECH;
            ST_PRECH:     if (cnt_zero) state_nx = ST_IDLE;
            ST_CBR_CAS:   if (cnt_zero) state_nx = ST_CBR_RAS;
            ST_CBR_RAS:   if (cnt_zero) state_nx = ST_CBR_PRECH;
            ST_CBR_PRECH: if (cnt_zero) state_nx = ST_IDLE;
        endcase
    end

    // duration of the state being entered, minus one
    always_comb begin
        cnt_load = '0;
        unique case (state_nx)
            ST_ROW:                 cnt_load = CW'(T_RCD - 1);
            ST_COL:                 cnt_load = CW'(T_COL - 1);
            ST_PRECH, ST_CBR_PRECH: cnt_load = CW'(T_PRE - 1);
            ST_CBR_CAS:             cnt_load = CW'(T_CSR - 1);
            ST_CBR_RAS:             cnt_load = CW'(T_RAS - 1);
            ST_POWERUP, ST_IDLE:    cnt_load = '0;
        endcase
    end

    // ---------------- counters and request latch ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= CW'(INIT_CYCLES - 1);
            init_cnt  <= '0;
            init_done <= 1'b0;
            lat_rank  <= '0;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_write <= 1'b0;
            lat_wdata <= '0;
            lat_be    <= '0;
        end else begin
            if (state_nx != state) cnt <= cnt_load;
            else if (!cnt_zero)    cnt <= cnt - 1'b1;

            if (state == ST_CBR_PRECH && cnt_zero && !init_done) begin
                if (init_cnt == IW'(INIT_REFS - 1)) init_done <= 1'b1;
                else                                init_cnt  <= init_cnt + 1'b1;
            end

            if (accept) begin
                lat_rank  <= req_addr[ROW_W+COL_W +: RANK_BITS];
                lat_row   <= req_addr[COL_W +: ROW_W];
                lat_col   <= req_addr[COL_W-1:0];
                lat_write <= req_write;
                lat_wdata <= req_wdata;
                lat_be    <= req_be;
            end
        end
    end

    edo_refresh_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (init_done),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    // ---------------- outputs ----------------
    always_comb begin
        row_act = 1'b0;
        col_act = 1'b0;
        ref_cas = 1'b0;
        ref_ras = 1'b0;
        unique case (state)
            ST_ROW:     row_act = 1'b1;
            ST_COL:     begin row_act = 1'b1; col_act = 1'b1; end
            ST_CBR_CAS: ref_cas = 1'b1;
            ST_CBR_RAS: begin ref_cas = 1'b1; ref_ras = 1'b1; end
            ST_POWERUP, ST_IDLE, ST_PRECH, ST_CBR_PRECH: ;
        endcase
    end

    edo_strobe_map #(
        .RANK_BITS (RANK_BITS),
        .DEVS      (DEVS),
        .LANES     (LANES)
    ) u_map (
        .rank    (lat_rank),
        .lanes   (lat_be),
        .row_act (row_act),
        .col_act (col_act),
        .ref_cas (ref_cas),
        .ref_ras (ref_ras),
        .ras_n   (mem_ras_n),
        .cas_n   (mem_cas_n)
    );

    assign mem_addr   = col_act ? MA_W'(lat_col) : MA_W'(lat_row);
    assign mem_we_n   = ~(lat_write & row_act);
    assign mem_dq_oe  = lat_write & row_act;
    assign mem_dq_out = lat_wdata;
    assign mem_oe_n   = ~(~lat_write & col_act);

    for (genvar j = 0; j < LANES; j++) begin : g_mask
        assign lane_mask[j*BYTE_W +: BYTE_W] = {BYTE_W{lat_be[j]}};
    end

    // read capture at the last column-phase edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == ST_COL) && cnt_zero && !lat_write;
            if ((state == ST_COL) && cnt_zero && !lat_write)
                rd_data <= mem_dq_in & lane_mask;
        end
    end
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
    parameter int RAS_LINES   = 4,
    parameter int DEVS        = 2,
    parameter int LANES       = 4,
    parameter int T_RAS       = 5,
    parameter int INIT_CYCLES = 20000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic                 rd_valid,
    input logic [RAS_LINES-1:0] ras_n,
    input logic [LANES-1:0]     cas_n,
    input logic                 we_n,
    input logic                 oe_n,
    input logic                 dq_oe
);
    localparam int PW = $clog2(INIT_CYCLES + 1);
    localparam int LW = $clog2(T_RAS + 2);

    logic [PW-1:0] since_rst;
    logic [LW-1:0] low_len;
    logic          all_ras, any_ras, acc_ras, cas_fall;

    assign all_ras  = (ras_n == '0);
    assign any_ras  = (ras_n != '1);
    assign acc_ras  = any_ras && !all_ras;
    assign cas_fall = (cas_n != '1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            low_len   <= '0;
        end else begin
            if (since_rst != PW'(INIT_CYCLES)) since_rst <= since_rst + 1'b1;
            if (!any_ras)                      low_len   <= '0;
            else if (low_len != LW'(T_RAS + 1)) low_len  <= low_len + 1'b1;
        end
    end

    assert_powerup_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < PW'(INIT_CYCLES)) |-> (ras_n == '1 && !req_ready));

    assert_cbr_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
        all_ras |-> (cas_n == '0 && we_n && oe_n));

    assert_cbr_cas_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (all_ras && !$past(all_ras)) |-> ($past(cas_n) == '0));

    assert_refresh_no_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (all_ras && !$past(all_ras)) |-> ($past(ras_n) == '1));

    assert_rank_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n == '1) || all_ras || ($countones(~ras_n) == DEVS));

    assert_early_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ras && cas_fall && $past(cas_n) == '1) |-> $stable(we_n));

    assert_oe_read_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !dq_oe));

    assert_rdvalid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_ras_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ras && $past(any_ras)) |-> (low_len >= LW'(T_RAS)));

    assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ras_n == '1 && cas_n == '1));
endmodule

bind edo_ctrl edo_ctrl_chk #(
    .RAS_LINES   (DEVS << RANK_BITS),
    .DEVS        (DEVS),
    .LANES       (DATA_W / 8),
    .T_RAS       (T_RAS),
    .INIT_CYCLES (INIT_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .ras_n     (mem_ras_n),
    .cas_n     (mem_cas_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe)
);

// File: tb/edo_ctrl_bench.sv
module edo_ctrl_bench;
    localparam int T_RCD = 2, T_RAS = 5, T_RP = 3, T_RC = 9, T_CSR = 1;
    localparam int REF_INTERVAL = 3125, INIT_CYCLES = 20000, INIT_REFS = 8;
    localparam int SLACK = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [9:0]  mem_addr;
    logic [3:0]  mem_ras_n, mem_cas_n;
    logic        mem_we_n, mem_oe_n, mem_dq_oe;
    logic [31:0] mem_dq_out;
    logic [31:0] dq_in_r = 32'h5A5A5A5A;

    always #4 clk = ~clk;

    edo_ctrl #(
        .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC), .T_CSR(T_CSR),
        .REF_INTERVAL(REF_INTERVAL), .INIT_CYCLES(INIT_CYCLES), .INIT_REFS(INIT_REFS)
    ) u_edo_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_in_r)
    );

    int total = 0, bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // ---------------- array model ----------------
    logic [31:0] mem [logic [20:0]];
    logic [9:0]  row_l [2];
    logic [9:0]  col_l;
    logic [3:0]  m_prev_ras = 4'hF, m_prev_cas = 4'hF;

    always @(negedge clk) begin
        logic r;
        logic [20:0] k;
        logic [31:0] w;
        r = (mem_ras_n == 4'b0101);
        if (mem_ras_n != 4'hF && mem_ras_n != 4'h0) begin
            if (m_prev_ras == 4'hF) row_l[r] = mem_addr;
            if (m_prev_cas == 4'hF && mem_cas_n != 4'hF) begin
                col_l = mem_addr;
                k = {r, row_l[r], col_l};
                if (!mem_we_n) begin
                    w = mem.exists(k) ? mem[k] : 32'h0;
                    for (int j = 0; j < 4; j++)
                        if (!mem_cas_n[j]) w[j*8 +: 8] = mem_dq_out[j*8 +: 8];
                    mem[k] = w;
                end
            end
        end
        if (!mem_oe_n && mem_cas_n != 4'hF && mem_ras_n != 4'hF) begin
            k = {r, row_l[r], col_l};
            w = mem.exists(k) ? mem[k] : 32'h0;
            for (int j = 0; j < 4; j++)
                dq_in_r[j*8 +: 8] = mem_cas_n[j] ? 8'hA5 : w[j*8 +: 8];
        end else begin
            dq_in_r = 32'h5A5A5A5A;
        end
        m_prev_ras = mem_ras_n;
        m_prev_cas = mem_cas_n;
    end

    // ---------------- protocol monitor ----------------
    logic        exp_rank = 1'b0, exp_write = 1'b0;
    logic [9:0]  exp_row = '0, exp_col = '0;
    logic [3:0]  exp_be = '0;
    logic [31:0] exp_wdata = '0;
    bit          in_traffic = 1'b0;

    int v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0, v_r8 = 0, v_r9 = 0, v_r10 = 0, v_r11 = 0;
    int ref_count = 0, ref_in_traffic = 0, last_ref = 0, first_fall = -1, acc_fall = 0;
    int low_len [2] = '{0, 0};
    int high_len [2] = '{0, 0};
    int last_fall [2] = '{0, 0};
    bit seen_fall [2] = '{1'b0, 1'b0};
    logic [3:0] p_ras = 4'hF, p_cas = 4'hF;
    logic       p_we = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (first_fall < 0 && mem_ras_n != 4'hF) first_fall = cyc;
            // refresh
            if (mem_ras_n == 4'h0) begin
                if (p_ras != 4'h0) begin
                    if (p_cas != 4'h0) v_r3++;
                    if (p_ras != 4'hF) v_r5++;
                    ref_count++;
                    if (in_traffic) ref_in_traffic++;
                    if (ref_count >= INIT_REFS + 2 &&
                        (cyc - last_ref > REF_INTERVAL + SLACK || cyc - last_ref < REF_INTERVAL - SLACK)) begin
                        v_r4++;
                        $display("note: R4 refresh gap %0d at cycle %0d", cyc - last_ref, cyc);
                    end
                    last_ref = cyc;
                end
                if (!mem_we_n || mem_cas_n != 4'h0) v_r3++;
            end
            // access
            if (mem_ras_n != 4'hF && mem_ras_n != 4'h0) begin
                if (mem_ras_n != (exp_rank ? 4'b0101 : 4'b1010)) v_r6++;
                if (p_ras == 4'hF) begin
                    acc_fall = cyc;
                    if (mem_addr != exp_row) v_r6++;
                end
                if (exp_write && !mem_oe_n) v_r8++;
                if (p_cas == 4'hF && mem_cas_n != 4'hF) begin
                    if (mem_cas_n != ~exp_be) v_r7++;
                    if (mem_addr != exp_col) v_r6++;
                    if (cyc - acc_fall != T_RCD) v_r10++;
                    if (exp_write) begin
                        if (mem_we_n || p_we || !mem_dq_oe || mem_dq_out != exp_wdata) v_r8++;
                    end else begin
                        if (!mem_we_n || mem_dq_oe || mem_oe_n) v_r9++;
                    end
                end
            end
            // per-rank widths
            for (int r = 0; r < 2; r++) begin
                if (!mem_ras_n[r]) begin
                    if (p_ras[r]) begin
                        if (seen_fall[r] && (high_len[r] < T_RP || cyc - last_fall[r] < T_RC)) v_r10++;
                        last_fall[r] = cyc;
                        seen_fall[r] = 1'b1;
                        low_len[r] = 0;
                    end
                    low_len[r]++;
                end else begin
                    if (!p_ras[r]) begin
                        if (low_len[r] < T_RAS) v_r10++;
                        high_len[r] = 0;
                    end
                    high_len[r]++;
                end
            end
            if (req_ready && (mem_ras_n != 4'hF || mem_cas_n != 4'hF)) v_r11++;
        end
        p_ras = mem_ras_n;
        p_cas = mem_cas_n;
        p_we  = mem_we_n;
    end

    // ---------------- scoreboard ----------------
    logic [31:0] exp_q [$];
    logic [31:0] shadow [logic [20:0]];

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected rd_valid", rd_data, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R9/R6/R7 read data", rd_data, e);
            end
        end
    end

    task automatic access(input bit wr, input logic [20:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] s, m;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        exp_rank = a[20]; exp_row = a[19:10]; exp_col = a[9:0];
        exp_be = be; exp_write = wr; exp_wdata = d;
        s = shadow.exists(a) ? shadow[a] : 32'h0;
        for (int j = 0; j < 4; j++) m[j*8 +: 8] = {8{be[j]}};
        if (wr) shadow[a] = (s & ~m) | (d & m);
        else    exp_q.push_back(s & m);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
        summary();
        $finish;
    end

    initial begin
        int ready_cyc, refs_before;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ras_n == 4'hF && mem_cas_n == 4'hF, "R1 reset strobes", {mem_ras_n, mem_cas_n}, 8'hFF);
        chk(mem_we_n && mem_oe_n && !req_ready, "R1 reset we/oe/ready", {mem_we_n, mem_oe_n, req_ready}, 3'b110);

        while (!req_ready) @(negedge clk);
        ready_cyc = cyc;
        chk(ready_cyc >= INIT_CYCLES, "R1 ready after pause", ready_cyc, INIT_CYCLES);
        chk(first_fall >= INIT_CYCLES, "R1 first row strobe after pause", first_fall, INIT_CYCLES);
        chk(ref_count == INIT_REFS, "R2 init refresh count", ref_count, INIT_REFS);

        // corner addresses, full words (R6)
        access(1, 21'h000000, 32'h0123_4567, 4'hF);
        access(1, 21'h1FFFFF, 32'hFEDC_BA98, 4'hF);
        access(1, 21'h100000, 32'hCAFE_F00D, 4'hF);
        access(1, 21'h0003FF, 32'h1357_9BDF, 4'hF);
        access(1, 21'h0FFC00, 32'h2468_ACE0, 4'hF);
        access(0, 21'h000000, '0, 4'hF);
        access(0, 21'h1FFFFF, '0, 4'hF);
        access(0, 21'h100000, '0, 4'hF);
        access(0, 21'h0003FF, '0, 4'hF);
        access(0, 21'h0FFC00, '0, 4'hF);
        // rank isolation: same row/column, other rank (R6)
        access(1, 21'h0ABCDE & 21'h0FFFFF, 32'h1111_1111, 4'hF);
        access(1, 21'h1ABCDE, 32'h2222_2222, 4'hF);
        access(0, 21'h0ABCDE & 21'h0FFFFF, '0, 4'hF);
        access(0, 21'h1ABCDE, '0, 4'hF);
        // byte lanes (R7, R9)
        access(1, 21'h012345, 32'h1122_3344, 4'hF);
        access(1, 21'h012345, 32'hAABB_CCDD, 4'b0101);
        access(0, 21'h012345, '0, 4'hF);
        access(0, 21'h012345, '0, 4'b1001);
        access(1, 21'h012345, 32'h9988_7766, 4'b1000);
        access(0, 21'h012345, '0, 4'b1010);
        access(0, 21'h012345, '0, 4'hF);

        // back-to-back stream across refresh deadlines (R4, R5)
        in_traffic = 1'b1;
        for (int i = 0; i < 200; i++)
            access(1, {i[0], 10'(i * 7), 10'(i * 13)}, 32'h0101_0101 * i ^ 32'h5EED_0000, 4'hF);
        for (int i = 0; i < 200; i++)
            access(0, {i[0], 10'(i * 7), 10'(i * 13)}, '0, (i % 3 == 0) ? 4'b0110 : 4'hF);
        in_traffic = 1'b0;
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
        chk(ref_in_traffic >= 1, "R5 refresh served during traffic", ref_in_traffic, 1);

        // quiet period (R4)
        refs_before = ref_count;
        repeat (3 * REF_INTERVAL + 200) @(negedge clk);
        chk(ref_count - refs_before >= 3, "R4 refreshes in idle window", ref_count - refs_before, 3);

        chk(v_r3 == 0, "R3 refresh ordering violations", v_r3, 0);
        chk(v_r4 == 0, "R4 refresh spacing violations", v_r4, 0);
        chk(v_r5 == 0, "R5 refresh cut into access", v_r5, 0);
        chk(v_r6 == 0, "R6 address/rank mapping violations", v_r6, 0);
        chk(v_r7 == 0, "R7 lane strobe violations", v_r7, 0);
        chk(v_r8 == 0, "R8 write cycle violations", v_r8, 0);
        chk(v_r9 == 0, "R9 read cycle violations", v_r9, 0);
        chk(v_r10 == 0, "R10 strobe timing violations", v_r10, 0);
        chk(v_r11 == 0, "R11 ready while busy", v_r11, 0);
        summary();
        $finish;
    end
endmodule